// File: doc/BRIEF.md
# Pixel Hit Column-Order Sorter

This block sits behind the hit input FIFO of one pixel readout chip. Every hit word in a crossing carries the same crossing counter. Inside a column the hits come in a fixed row order, but the columns themselves come in any order, and hits from different columns may interleave. The sorter regroups a whole crossing so that the output stream presents it column by column in ascending column number. Hits inside one column leave in the order they arrived.

Each accepted hit is written into a fixed-depth slot picked directly by its column number. No comparison sort is involved. A crossing is closed by either of two events: a hit whose crossing counter differs from the one being collected, or an explicit marker beat on the input. The sorter then stalls its input and drains the slots from column 0 upward. Columns with no hits are passed over without producing beats. The last hit of the crossing carries an end-of-crossing tag. Hits with an impossible column number, and hits beyond a slot's capacity, are dropped, and each kind sets its own sticky flag.

Top module: `hit_col_sorter`

## Requirements
- R1: A hit word is 24 bits: row in [23:17], column in [16:12], crossing counter in [11:4], ADC value in [3:1], sync in [0]. A hit whose column is 22 or more is dropped and never appears on the output. It sets `badcol_flag`, which stays high until reset.
- R2: Within one crossing, output beats appear in ascending column order, whatever order the columns arrived in. Columns without hits produce no beats.
- R3: Hits of the same column leave in the order they were accepted.
- R4: Each column holds at most 8 hits per crossing. A further hit to that column is dropped and sets `ovf_flag`, which stays high until reset. The first 8 hits and all other columns are unaffected. Slots are empty again for the next crossing.
- R5: A hit whose crossing counter differs from the crossing being collected closes that crossing. The hit is held off with `in_ready` low rather than accepted, and it is then accepted as the first hit of the next crossing.
- R6: An input beat with `in_mark`=1 is an end marker. It closes the current crossing, and its `in_hit` bits are ignored: it never produces an output beat and never closes a crossing by its counter.
- R7: `in_ready` is low from the cycle after a crossing is closed until the drain has finished.
- R8: `out_eoc` is 1 on exactly the last output beat of each crossing and 0 on all others. A crossing that stored no hits produces no output beats.
- R9: While `out_valid` is high and `out_ready` is low, `out_hit` and `out_eoc` hold their values. No beat is lost or repeated under backpressure.
- R10: After reset, `out_valid`=0, `in_ready`=1, and both sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_mark | input | 1 | Beat is an end marker, not a hit |
| in_hit | input | 24 | Hit word (layout in R1) |
| in_ready | output | 1 | Sorter accepts the input beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_hit | output | 24 | Sorted hit word |
| out_eoc | output | 1 | Last hit of the crossing |
| ovf_flag | output | 1 | Sticky: a hit was dropped because its column slot was full |
| badcol_flag | output | 1 | Sticky: a hit with column 22 or more was dropped |

## Verification
The bench feeds interleaved columns with rows deliberately out of numeric order. A design that sorted by row, or mixed up slot addresses, would produce beats out of column order or a reordered column. It pushes a ninth hit into one column and columns 25 and 31 into the stream. A design with an off-by-one slot bound would leak a ninth beat or lose the eighth, and one without a range check would alias the bad columns onto real slots. It changes the crossing counter mid-stream and sends a marker that carries a foreign counter. A design that swallowed the held hit, or compared the marker's bits, would lose a hit or split a crossing wrongly. Random output backpressure exposes a read pipeline that drops or duplicates beats.

// File: rtl/colsort_pkg.sv
`timescale 1ns/1ps
package colsort_pkg;
  localparam int ROW_W = 7;
  localparam int COL_W = 5;
  localparam int TS_W  = 8;
  localparam int ADC_W = 3;

  typedef struct packed {
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [TS_W-1:0]  ts;
    logic [ADC_W-1:0] adc;
    logic             sync;
  } hit_t;

  localparam int HIT_W = $bits(hit_t);
endpackage

// File: rtl/colsort_store.sv
`timescale 1ns/1ps
// Simple dual-port storage with a registered read port, shaped for block RAM.
module colsort_store #(
  parameter int DEPTH  = 176,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/colsort_fill.sv
`timescale 1ns/1ps
// Collect side: per-column fill counters, crossing tracking, drop decisions.
module colsort_fill import colsort_pkg::*; #(
  parameter int NUM_COLS   = 22,
  parameter int SLOT_DEPTH = 8,
  parameter int CNT_W      = 4,
  parameter int HELD_W     = 8,
  parameter int ADDR_W     = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             fill_en,
  input  logic                             in_valid,
  input  logic                             in_mark,
  input  hit_t                             in_hit,
  input  logic                             drain_done,
  output logic                             in_ready,
  output logic                             start_drain,
  output logic                             wr_en,
  output logic [ADDR_W-1:0]                wr_addr,
  output logic [HIT_W-1:0]                 wr_data,
  output logic [NUM_COLS-1:0][CNT_W-1:0]   col_cnt,
  output logic [HELD_W-1:0]                held,
  output logic                             ovf_flag,
  output logic                             badcol_flag
);
  logic             have_ts;
  logic [TS_W-1:0]  cur_ts;
  logic             ts_change;
  logic             acc_hit;
  logic             col_ok;
  logic [COL_W-1:0] col_idx;
  logic [CNT_W-1:0] sel_cnt;
  logic             slot_full;

  always_comb begin
    ts_change   = have_ts && !in_mark && (in_hit.ts != cur_ts);
    in_ready    = fill_en && !(in_valid && ts_change);
    start_drain = fill_en && in_valid && (in_mark || ts_change);
    acc_hit     = in_valid && in_ready && !in_mark;
    col_ok      = int'(in_hit.col) < NUM_COLS;
    col_idx     = col_ok ? in_hit.col : '0;
    sel_cnt     = col_cnt[col_idx];
    slot_full   = sel_cnt == CNT_W'(SLOT_DEPTH);
    wr_en       = acc_hit && col_ok && !slot_full;
    wr_addr     = ADDR_W'(int'(col_idx) * SLOT_DEPTH + int'(sel_cnt));
    wr_data     = in_hit;
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst || drain_done) col_cnt[c] <= '0;
      else if (wr_en && col_idx == COL_W'(c)) col_cnt[c] <= col_cnt[c] + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || drain_done) begin
      held    <= '0;
      have_ts <= 1'b0;
      cur_ts  <= '0;
    end else if (wr_en) begin
      held <= held + HELD_W'(1);
      if (!have_ts) begin
        have_ts <= 1'b1;
        cur_ts  <= in_hit.ts;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag    <= 1'b0;
      badcol_flag <= 1'b0;
    end else begin
      if (acc_hit && col_ok && slot_full) ovf_flag <= 1'b1;
      if (acc_hit && !col_ok) badcol_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/colsort_drain.sv
`timescale 1ns/1ps
// Drain side: walks columns upward, issues reads, owns the output handshake.
module colsort_drain #(
  parameter int NUM_COLS   = 22,
  parameter int SLOT_DEPTH = 8,
  parameter int CNT_W      = 4,
  parameter int HELD_W     = 8,
  parameter int ADDR_W     = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [NUM_COLS-1:0][CNT_W-1:0] col_cnt,
  input  logic [HELD_W-1:0]              held,
  input  logic                           out_ready,
  output logic                           busy,
  output logic                           done,
  output logic                           rd_en,
  output logic [ADDR_W-1:0]              rd_addr,
  output logic                           out_valid,
  output logic                           out_eoc
);
  localparam int IDX_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;

  logic [IDX_W-1:0]  col;
  logic [CNT_W-1:0]  idx;
  logic [HELD_W-1:0] remain;
  logic              can_issue;
  logic              col_done;

  always_comb begin
    can_issue = !out_valid || out_ready;
    col_done  = idx == col_cnt[col];
    done      = busy && (remain == '0);
    rd_en     = busy && (remain != '0) && !col_done && can_issue;
    rd_addr   = ADDR_W'(int'(col) * SLOT_DEPTH + int'(idx));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      col    <= '0;
      idx    <= '0;
      remain <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      col    <= '0;
      idx    <= '0;
      remain <= held;
    end else if (busy) begin
      if (remain == '0) begin
        busy <= 1'b0;
      end else if (col_done) begin
        col <= col + IDX_W'(1);
        idx <= '0;
      end else if (can_issue) begin
        idx    <= idx + CNT_W'(1);
        remain <= remain - HELD_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_eoc   <= 1'b0;
    end else if (rd_en) begin
      out_valid <= 1'b1;
      out_eoc   <= remain == HELD_W'(1);
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_eoc   <= 1'b0;
    end
  end
endmodule

// File: rtl/hit_col_sorter.sv
`timescale 1ns/1ps
module hit_col_sorter import colsort_pkg::*; #(
  parameter int NUM_COLS   = 22,
  parameter int SLOT_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_mark,
  input  logic [HIT_W-1:0] in_hit,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [HIT_W-1:0] out_hit,
  output logic             out_eoc,
  output logic             ovf_flag,
  output logic             badcol_flag
);
  localparam int TOTAL  = NUM_COLS * SLOT_DEPTH;
  localparam int CNT_W  = $clog2(SLOT_DEPTH + 1);
  localparam int HELD_W = $clog2(TOTAL + 1);
  localparam int ADDR_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  logic                           drain_busy;
  logic                           drain_done;
  logic                           start_drain;
  logic                           wr_en;
  logic [ADDR_W-1:0]              wr_addr;
  logic [HIT_W-1:0]               wr_data;
  logic                           rd_en;
  logic [ADDR_W-1:0]              rd_addr;
  logic [NUM_COLS-1:0][CNT_W-1:0] col_cnt;
  logic [HELD_W-1:0]              held;

  colsort_fill #(
    .NUM_COLS(NUM_COLS), .SLOT_DEPTH(SLOT_DEPTH),
    .CNT_W(CNT_W), .HELD_W(HELD_W), .ADDR_W(ADDR_W)
  ) u_fill (
    .clk(clk), .rst(rst), .fill_en(!drain_busy),
    .in_valid(in_valid), .in_mark(in_mark), .in_hit(hit_t'(in_hit)),
    .drain_done(drain_done), .in_ready(in_ready), .start_drain(start_drain),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .col_cnt(col_cnt), .held(held),
    .ovf_flag(ovf_flag), .badcol_flag(badcol_flag)
  );

  colsort_store #(.DEPTH(TOTAL), .ADDR_W(ADDR_W), .DATA_W(HIT_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(out_hit)
  );

  colsort_drain #(
    .NUM_COLS(NUM_COLS), .SLOT_DEPTH(SLOT_DEPTH),
    .CNT_W(CNT_W), .HELD_W(HELD_W), .ADDR_W(ADDR_W)
  ) u_drain (
    .clk(clk), .rst(rst), .start(start_drain), .col_cnt(col_cnt), .held(held),
    .out_ready(out_ready), .busy(drain_busy), .done(drain_done),
    .rd_en(rd_en), .rd_addr(rd_addr), .out_valid(out_valid), .out_eoc(out_eoc)
  );
endmodule

// File: rtl/hit_col_sorter_chk.sv
`timescale 1ns/1ps
module hit_col_sorter_chk import colsort_pkg::*; #(
  parameter int NUM_COLS = 22
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [HIT_W-1:0] out_hit,
  input logic             out_eoc,
  input logic             ovf_flag,
  input logic             badcol_flag,
  input logic             busy
);
  hit_t             oh;
  logic             in_seq;
  logic [COL_W-1:0] last_col;

  assign oh = hit_t'(out_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_seq   <= 1'b0;
      last_col <= '0;
    end else if (out_valid && out_ready) begin
      in_seq   <= !out_eoc;
      last_col <= oh.col;
    end
  end

  // R2
  col_order_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && in_seq) |-> (oh.col >= last_col));

  // R1
  out_col_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(oh.col) < NUM_COLS));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_eoc)));

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  // R1
  badcol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    badcol_flag |=> badcol_flag);

  // R8
  eoc_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_eoc |-> out_valid);
endmodule

bind hit_col_sorter hit_col_sorter_chk #(.NUM_COLS(NUM_COLS)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_hit(out_hit), .out_eoc(out_eoc),
  .ovf_flag(ovf_flag), .badcol_flag(badcol_flag), .busy(drain_busy)
);

// File: tb/hit_col_sorter_bench.sv
`timescale 1ns/1ps
module hit_col_sorter_bench;
  localparam int NCOL = 22;
  localparam int DEP  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_mark = 1'b0;
  logic [23:0] in_hit = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_hit;
  logic        out_eoc;
  logic        ovf_flag;
  logic        badcol_flag;

  always #2.5 clk = ~clk;

  hit_col_sorter u_hit_col_sorter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mark(in_mark), .in_hit(in_hit),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_eoc(out_eoc), .ovf_flag(ovf_flag), .badcol_flag(badcol_flag)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [24:0] gotq[$];
  logic [24:0] expq[$];
  logic [23:0] listq[$];
  bit          bp_mode = 1'b0;
  logic [7:0]  lfsr = 8'hA5;

  // Output monitor: ready is updated and the handshake sampled in one process.
  always @(negedge clk) begin
    if (bp_mode) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0];
    end else begin
      out_ready = 1'b1;
    end
    if (!rst && out_valid && out_ready) gotq.push_back({out_eoc, out_hit});
  end

  function automatic logic [23:0] mk(int row, int col, int ts, int adc, int snc);
    return {7'(row), 5'(col), 8'(ts), 3'(adc), 1'(snc)};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] h, input bit mark);
    @(negedge clk);
    in_valid = 1'b1; in_hit = h; in_mark = mark;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_mark = 1'b0;
  endtask

  task automatic send_list();
    foreach (listq[i]) send(listq[i], 1'b0);
  endtask

  // Expected order from the requirements: ascending column, arrival order,
  // at most DEP per column, columns >= NCOL dropped, last beat tagged.
  function automatic void add_expected(logic [23:0] hits[$]);
    int first = expq.size();
    for (int c = 0; c < NCOL; c++) begin
      int cnt = 0;
      foreach (hits[i]) begin
        if (int'(hits[i][16:12]) == c) begin
          if (cnt < DEP) expq.push_back({1'b0, hits[i]});
          cnt++;
        end
      end
    end
    if (expq.size() > first) expq[expq.size()-1][24] = 1'b1;
  endfunction

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!(in_ready && !out_valid)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(string req);
    wait_idle();
    check(gotq.size() == expq.size(), req, "beat count", gotq.size(), expq.size());
    for (int i = 0; i < gotq.size() && i < expq.size(); i++)
      check(gotq[i] == expq[i], req, $sformatf("beat %0d {eoc,hit}", i), gotq[i], expq[i]);
    gotq.delete(); expq.delete(); listq.delete();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    check(ovf_flag == 1'b0, "R10", "ovf_flag after reset", ovf_flag, 0);
    check(badcol_flag == 1'b0, "R10", "badcol_flag after reset", badcol_flag, 0);
  endtask

  // R2 R8: interleaved columns in scrambled order
  task automatic t_scramble();
    listq = '{mk(4,13,7,1,0), mk(9,2,7,2,1), mk(5,13,7,3,0), mk(1,21,7,4,0),
              mk(0,0,7,5,1), mk(10,2,7,6,0), mk(33,7,7,7,0), mk(2,21,7,0,1)};
    send_list();
    add_expected(listq);
    send('0, 1'b1);
    compare("R2");
  endtask

  // R3: arrival order within a column is kept, not numeric row order
  task automatic t_roworder();
    listq = '{mk(90,7,3,1,0), mk(10,7,3,2,0), mk(50,7,3,3,0), mk(3,4,3,4,0)};
    send_list();
    add_expected(listq);
    send('0, 1'b1);
    compare("R3");
  endtask

  // R5: crossing counter change closes the crossing, held hit starts the next
  task automatic t_ts_change();
    logic [23:0] a[$];
    logic [23:0] b[$];
    a = '{mk(1,9,5,0,0), mk(2,3,5,1,0), mk(3,9,5,2,0)};
    b = '{mk(4,1,6,3,0), mk(5,0,6,4,1)};
    listq = {a, b};
    send_list();
    add_expected(a);
    add_expected(b);
    send('0, 1'b1);
    compare("R5");
  endtask

  // R6 R8: empty crossing, and a marker carrying a foreign counter
  task automatic t_marker();
    send(mk(5,2,200,1,1), 1'b1);
    compare("R8");
    listq = '{mk(6,4,9,1,0)};
    send_list();
    add_expected(listq);
    send(mk(8,1,200,2,1), 1'b1);
    compare("R6");
  endtask

  // R9: random backpressure on the output
  task automatic t_backpressure();
    bp_mode = 1'b1;
    for (int i = 0; i < 20; i++) listq.push_back(mk(i, (i * 7) % NCOL, 11, i % 8, i % 2));
    send_list();
    add_expected(listq);
    send('0, 1'b1);
    compare("R9");
    bp_mode = 1'b0;
  endtask

  task automatic t_flags_clean();
    check(ovf_flag == 1'b0, "R4", "ovf_flag after legal traffic", ovf_flag, 0);
    check(badcol_flag == 1'b0, "R1", "badcol_flag after legal traffic", badcol_flag, 0);
  endtask

  // R1: columns 25 and 31 dropped
  task automatic t_badcol();
    listq = '{mk(1,3,2,0,0), mk(2,25,2,0,0), mk(3,31,2,0,0), mk(4,1,2,0,0)};
    send_list();
    add_expected(listq);
    send('0, 1'b1);
    compare("R1");
    check(badcol_flag == 1'b1, "R1", "badcol_flag set", badcol_flag, 1);
    check(ovf_flag == 1'b0, "R4", "ovf_flag untouched by bad column", ovf_flag, 0);
  endtask

  // R4: ninth and tenth hits of column 5 dropped; next crossing starts empty
  task automatic t_overflow();
    for (int i = 0; i < 10; i++) listq.push_back(mk(i, 5, 4, 0, 0));
    listq.push_back(mk(20, 6, 4, 0, 0));
    send_list();
    add_expected(listq);
    send('0, 1'b1);
    compare("R4");
    check(ovf_flag == 1'b1, "R4", "ovf_flag set", ovf_flag, 1);
    for (int i = 0; i < 8; i++) listq.push_back(mk(i + 40, 5, 8, 1, 0));
    send_list();
    add_expected(listq);
    send('0, 1'b1);
    compare("R4");
    check(ovf_flag == 1'b1, "R4", "ovf_flag still set", ovf_flag, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_scramble();
    t_roworder();
    t_ts_change();
    t_marker();
    t_backpressure();
    t_flags_clean();
    t_badcol();
    t_overflow();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule